// File: doc/BRIEF.md
# Single-Phase PCI Register Read Target

This block answers PCI read cycles that fall in a small, aligned window of operation registers. It watches the bus for the start of a transaction and compares the address with a fixed base. It accepts only memory-read and I/O-read commands. When a cycle is claimed, it returns one 32-bit word from a register bank that the surrounding core supplies. One slot of the window is a FIFO read port. That slot returns the FIFO head and pops the FIFO only when the word has actually been transferred on the bus.

Every transaction carries at most one data phase. If the initiator shows that it wants more, the target delivers the first word and signals a disconnect at the same time. A read of the FIFO slot while the FIFO is empty gets a retry: STOP# is asserted and no data is transferred. All control outputs are active-low. Each one has its own output enable, so the pads can float outside a transaction. After the initiator ends the cycle, the target drives the controls high for one clock and then releases them.

Top module: `pci_rdtgt`

## Requirements
- R1: While reset is held, every output enable (devsel_oe, trdy_oe, stop_oe, ad_oe) is 0. devsel_n, trdy_n and stop_n are 1, and fifo_pop is 0.
- R2: An address phase is the first clock in which frame_n is sampled low after it was high. The cycle is claimed only when three conditions hold: ad_in[31:5] equals BASE_ADDR[31:5]; cbe_n is 4'b0110 (memory read) with ad_in[1:0] == 2'b00, or cbe_n is 4'b0010 (I/O read) with any ad_in[1:0]; and the target is idle. A claimed cycle drives devsel_n low, with devsel_oe 1, in the clock after the address phase. Any other cycle leaves all enables at 0.
- R3: In a claimed non-retry cycle, trdy_n goes low in the clock after the first edge at which irdy_n is sampled low. In that same clock, ad_out carries the word of register index ad_in[4:2] and ad_oe is 1.
- R4: frame_n held low while irdy_n is high counts as wait states and not as a burst. In that state stop_n and trdy_n stay high and devsel_n stays low.
- R5: Once trdy_n is low, it stays low with ad_out unchanged until an edge at which irdy_n is sampled low.
- R6: If frame_n is still low at the edge where irdy_n is first sampled low, stop_n goes low together with trdy_n. After the transfer, trdy_n returns high. stop_n and devsel_n stay low until frame_n is sampled high.
- R7: If frame_n is high at that edge, stop_n stays high. After the transfer edge, devsel_n, trdy_n and stop_n are driven high with their enables at 1 for exactly one clock. In the following clock all enables are 0.
- R8: A read of index FIFO_INDEX (3) while fifo_empty is 1 drives stop_n low in the clock after the first data-phase edge, and trdy_n never goes low. stop_n and devsel_n stay low until frame_n is sampled high. No pop occurs.
- R9: fifo_pop is 1 for exactly one clock, during the clock whose closing edge completes the transfer (irdy_n and trdy_n both low), and only for index FIFO_INDEX. That transfer returns fifo_data. Reads of other indices never pop.
- R10: stop_n is driven low while trdy_n has not been low in the transaction only in the empty-FIFO retry case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Cycle frame from initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data lines as seen by the target |
| cbe_n | input | 4 | Command in address phase, byte enables afterwards |
| reg_bank | input | 256 | Operation register values, word i at bits [32*i+31:32*i] |
| fifo_data | input | 32 | Head word of the FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Remove the head word of the FIFO |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Enable for ad_out |
| devsel_n | output | 1 | Device select, active low |
| devsel_oe | output | 1 | Enable for devsel_n |
| trdy_n | output | 1 | Target ready, active low |
| trdy_oe | output | 1 | Enable for trdy_n |
| stop_n | output | 1 | Target stop, active low |
| stop_oe | output | 1 | Enable for stop_n |

## Verification
A controller left in the wrong state shows up at the pins within one or two clocks. A missed claim or an extra claim appears on devsel_n in the clock right after the address phase. A lost burst decision appears as stop_n high beside a low trdy_n. A stuck termination state keeps devsel_n or stop_n low after frame_n has risen. A wrong latched slot selection shows either as the wrong ad_out word, or as a fifo_pop pulse that is missing or extra at the transfer edge. So each scenario compares the pins clock by clock and also counts pops across whole transactions.

// File: rtl/pci_rdtgt_pkg.sv
// Shared definitions for the single-phase register read target.
// Assumes a 32-bit multiplexed address/data bus.
package pci_rdtgt_pkg;
    localparam int BUS_W = 32;
    localparam int CMD_W = 4;

    // Bus command codes as they appear on cbe_n during the address phase
    localparam logic [CMD_W-1:0] CMD_IO_READ  = 4'b0010;
    localparam logic [CMD_W-1:0] CMD_MEM_READ = 4'b0110;

    // Target controller states
    typedef enum logic [2:0] {
        ST_IDLE,   // bus watched, nothing driven
        ST_WAIT,   // claimed, waiting for the initiator to become ready
        ST_DATA,   // TRDY# asserted, word on the bus
        ST_TERM,   // STOP# held until FRAME# rises
        ST_TURN    // controls driven high for one clock before release
    } tgt_state_e;
endpackage

// File: rtl/pci_rdtgt_decode.sv
// Address and command decode for the register window.
// Purely combinational; the caller qualifies the result with the
// address-phase timing. Assumes NUM_REGS is a power of two >= 2 and that
// BASE_ADDR is aligned to the window size.
module pci_rdtgt_decode
    import pci_rdtgt_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR  = 32'h4000_0000,
    parameter int               NUM_REGS   = 8,
    parameter int               FIFO_INDEX = 3,
    parameter int               IDX_W      = 3
) (
    input  logic [BUS_W-1:0] ad_in,
    input  logic [CMD_W-1:0] cbe_n,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic             is_fifo
);
    localparam int            WIN_BITS = IDX_W + 2;
    localparam logic [IDX_W-1:0] FIFO_SEL = IDX_W'(FIFO_INDEX);

    logic in_window;
    logic cmd_ok;

    // Window compare, command check and slot extraction
    always_comb begin
        in_window = (ad_in[BUS_W-1:WIN_BITS] == BASE_ADDR[BUS_W-1:WIN_BITS]);
        cmd_ok    = ((cbe_n == CMD_MEM_READ) && (ad_in[1:0] == 2'b00)) ||
                    (cbe_n == CMD_IO_READ);
        hit       = in_window && cmd_ok && (NUM_REGS > 0);
        idx       = ad_in[WIN_BITS-1:2];
        is_fifo   = (idx == FIFO_SEL);
    end
endmodule

// File: rtl/pci_rdtgt_rdmux.sv
// Read data selection: picks one word of the flat register bank, or the
// FIFO head when the latched slot is the FIFO port. Combinational.
module pci_rdtgt_rdmux
    import pci_rdtgt_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_REGS*BUS_W-1:0] reg_bank,
    input  logic [BUS_W-1:0]          fifo_data,
    input  logic [IDX_W-1:0]          sel_idx,
    input  logic                      sel_fifo,
    output logic [BUS_W-1:0]          rd_word
);
    logic [BUS_W-1:0] words [NUM_REGS];

    // Unpack the flat bank into an indexable array
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_unpack
        assign words[gi] = reg_bank[gi*BUS_W +: BUS_W];
    end

    // Final word: FIFO head overrides the bank slot
    always_comb begin
        rd_word = sel_fifo ? fifo_data : words[sel_idx];
    end
endmodule

// File: rtl/pci_rdtgt_fsm.sv
// Target controller. It claims decoded cycles with fast DEVSEL# timing,
// holds TRDY# off until the initiator is ready so the burst intent is
// known, and ends every cycle after one data phase (disconnect with data)
// or with a retry for an empty FIFO. All outputs are registered except
// fifo_pop, which marks the transfer edge.
// Assumes legal initiator behaviour: a new cycle starts only after FRAME#
// has been high.
module pci_rdtgt_fsm
    import pci_rdtgt_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             dec_hit,
    input  logic [IDX_W-1:0] dec_idx,
    input  logic             dec_fifo,
    input  logic             fifo_empty,
    input  logic [BUS_W-1:0] rd_word,
    output logic [IDX_W-1:0] sel_idx,
    output logic             sel_fifo,
    output logic             fifo_pop,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic             devsel_n,
    output logic             devsel_oe,
    output logic             trdy_n,
    output logic             trdy_oe,
    output logic             stop_n,
    output logic             stop_oe
);
    tgt_state_e state;
    logic       frame_q;
    logic       xfer;

    // A word moves when the initiator is ready during the data state
    always_comb begin
        xfer     = (state == ST_DATA) && !irdy_n;
        fifo_pop = xfer && sel_fifo;
    end

    // Transaction sequencing and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            frame_q   <= 1'b1;
            sel_idx   <= '0;
            sel_fifo  <= 1'b0;
            ad_out    <= '0;
            ad_oe     <= 1'b0;
            devsel_n  <= 1'b1;
            devsel_oe <= 1'b0;
            trdy_n    <= 1'b1;
            trdy_oe   <= 1'b0;
            stop_n    <= 1'b1;
            stop_oe   <= 1'b0;
        end else begin
            frame_q <= frame_n;
            case (state)
                ST_IDLE: begin
                    if (!frame_n && frame_q && dec_hit) begin
                        sel_idx   <= dec_idx;
                        sel_fifo  <= dec_fifo;
                        devsel_n  <= 1'b0;
                        devsel_oe <= 1'b1;
                        trdy_n    <= 1'b1;
                        trdy_oe   <= 1'b1;
                        stop_n    <= 1'b1;
                        stop_oe   <= 1'b1;
                        state     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (sel_fifo && fifo_empty) begin
                        stop_n <= 1'b0;
                        state  <= ST_TERM;
                    end else if (!irdy_n) begin
                        trdy_n <= 1'b0;
                        stop_n <= frame_n;
                        ad_out <= rd_word;
                        ad_oe  <= 1'b1;
                        state  <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (xfer) begin
                        trdy_n <= 1'b1;
                        ad_oe  <= 1'b0;
                        if (frame_n) begin
                            devsel_n <= 1'b1;
                            stop_n   <= 1'b1;
                            state    <= ST_TURN;
                        end else begin
                            stop_n <= 1'b0;
                            state  <= ST_TERM;
                        end
                    end
                end
                ST_TERM: begin
                    if (frame_n) begin
                        devsel_n <= 1'b1;
                        stop_n   <= 1'b1;
                        trdy_n   <= 1'b1;
                        state    <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    devsel_oe <= 1'b0;
                    trdy_oe   <= 1'b0;
                    stop_oe   <= 1'b0;
                    ad_oe     <= 1'b0;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pci_rdtgt.sv
// Top of the single-phase register read target. It ties together the
// address decode, the read-data select and the controller. Assumes
// NUM_REGS is a power of two >= 2, FIFO_INDEX < NUM_REGS, and a BASE_ADDR
// aligned to NUM_REGS*4 bytes.
module pci_rdtgt
    import pci_rdtgt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int          NUM_REGS   = 8,
    parameter int          FIFO_INDEX = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    input  logic [31:0]          ad_in,
    input  logic [3:0]           cbe_n,
    input  logic [NUM_REGS*32-1:0] reg_bank,
    input  logic [31:0]          fifo_data,
    input  logic                 fifo_empty,
    output logic                 fifo_pop,
    output logic [31:0]          ad_out,
    output logic                 ad_oe,
    output logic                 devsel_n,
    output logic                 devsel_oe,
    output logic                 trdy_n,
    output logic                 trdy_oe,
    output logic                 stop_n,
    output logic                 stop_oe
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic             addr_hit;
    logic [IDX_W-1:0] addr_idx;
    logic             addr_fifo;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_fifo;
    logic [BUS_W-1:0] rd_word;

    pci_rdtgt_decode #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS),
        .FIFO_INDEX(FIFO_INDEX),
        .IDX_W     (IDX_W)
    ) u_decode (
        .ad_in  (ad_in),
        .cbe_n  (cbe_n),
        .hit    (addr_hit),
        .idx    (addr_idx),
        .is_fifo(addr_fifo)
    );

    pci_rdtgt_rdmux #(
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) u_rdmux (
        .reg_bank (reg_bank),
        .fifo_data(fifo_data),
        .sel_idx  (sel_idx),
        .sel_fifo (sel_fifo),
        .rd_word  (rd_word)
    );

    pci_rdtgt_fsm #(
        .IDX_W(IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .dec_hit   (addr_hit),
        .dec_idx   (addr_idx),
        .dec_fifo  (addr_fifo),
        .fifo_empty(fifo_empty),
        .rd_word   (rd_word),
        .sel_idx   (sel_idx),
        .sel_fifo  (sel_fifo),
        .fifo_pop  (fifo_pop),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .devsel_n  (devsel_n),
        .devsel_oe (devsel_oe),
        .trdy_n    (trdy_n),
        .trdy_oe   (trdy_oe),
        .stop_n    (stop_n),
        .stop_oe   (stop_oe)
    );
endmodule

// File: rtl/pci_rdtgt_chk.sv
// Protocol checker for the read target, bound to the top module.
// It observes only and drives nothing.
module pci_rdtgt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic        fifo_empty,
    input logic        fifo_pop,
    input logic [31:0] ad_out,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        trdy_oe,
    input logic        stop_n,
    input logic        addr_hit
);
    // Claim comes one clock after a decoded address phase
    assert_fast_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> ($past(addr_hit) && !$past(frame_n)));

    // TRDY# only follows an edge where the initiator was ready
    assert_trdy_after_irdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> !$past(irdy_n));

    // STOP# beside TRDY# only when the initiator was ready
    assert_wait_no_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stop_n) && !trdy_n) |-> !$past(irdy_n));

    // Data and TRDY# hold through initiator wait states
    assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));

    // Burst intent at TRDY# assertion gives a disconnect with data
    assert_burst_disconnect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trdy_n) && !$past(frame_n)) |-> !stop_n);

    // Last-phase transfer releases all controls high
    assert_single_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n && stop_n) |=> (devsel_n && trdy_n && stop_n));

    // FIFO pops only on a completed transfer
    assert_pop_on_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!irdy_n && !trdy_n && trdy_oe));

    // STOP# without TRDY# only as an empty-FIFO retry
    assert_stop_alone_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stop_n) && trdy_n) |-> $past(fifo_empty));
endmodule

bind pci_rdtgt pci_rdtgt_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .fifo_empty(fifo_empty),
    .fifo_pop  (fifo_pop),
    .ad_out    (ad_out),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .trdy_oe   (trdy_oe),
    .stop_n    (stop_n),
    .addr_hit  (addr_hit)
);

// File: tb/pci_rdtgt_tb.sv
// Directed bench for the single-phase register read target. Inputs change
// on the falling clock edge and outputs are sampled there too.
module pci_rdtgt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [3:0]  MEMRD = 4'b0110;
    localparam logic [3:0]  IORD  = 4'b0010;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_n = 1'b1;
    logic               irdy_n = 1'b1;
    logic [31:0]        ad_in = '0;
    logic [3:0]         cbe_n = 4'hF;
    logic [NREG*32-1:0] reg_bank;
    logic [31:0]        fifo_data = 32'hF1F0_0001;
    logic               fifo_empty = 1'b1;
    logic               fifo_pop;
    logic [31:0]        ad_out;
    logic               ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe;

    int n_checks = 0;
    int n_errs   = 0;
    int pop_count = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_rdtgt #(.BASE_ADDR(BASE), .NUM_REGS(NREG), .FIFO_INDEX(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .cbe_n(cbe_n), .reg_bank(reg_bank),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n),
        .devsel_oe(devsel_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe),
        .stop_n(stop_n), .stop_oe(stop_oe)
    );

    always @(posedge clk) if (fifo_pop) pop_count <= pop_count + 1;

    function automatic logic [31:0] bank_word(input int i);
        return 32'hA500_0000 | (i * 32'h111);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_idle();
        frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
        step(); step();
    endtask

    // Address phase; returns after the address edge has passed
    task automatic addr_phase(input logic [31:0] a, input logic [3:0] cmd);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = cmd;
        step();
        ad_in = '0; cbe_n = 4'h0;
    endtask

    task automatic check_released(input string req);
        check({req, " enables off"}, {28'd0, devsel_oe, trdy_oe, stop_oe, ad_oe}, 32'd0);
    endtask

    task automatic check_driven_high(input string req);
        check({req, " ctl high"}, {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
        check({req, " ctl oe"}, {29'd0, devsel_oe, trdy_oe, stop_oe}, 32'd7);
    endtask

    task automatic t_reset();
        step();
        check("R1 enables", {28'd0, devsel_oe, trdy_oe, stop_oe, ad_oe}, 32'd0);
        check("R1 levels", {28'd0, devsel_n, trdy_n, stop_n, fifo_pop}, 32'he);
    endtask

    task automatic t_single_reg();
        int p0 = pop_count;
        addr_phase(BASE + 32'd20, MEMRD);
        check("R2 devsel", {31'd0, devsel_n}, 32'd0);
        check("R2 devsel_oe", {31'd0, devsel_oe}, 32'd1);
        check("R3 trdy before irdy", {31'd0, trdy_n}, 32'd1);
        frame_n = 1'b1; irdy_n = 1'b0;
        step();
        check("R3 trdy", {31'd0, trdy_n}, 32'd0);
        check("R3 data", ad_out, bank_word(5));
        check("R3 ad_oe", {31'd0, ad_oe}, 32'd1);
        check("R7 no stop", {31'd0, stop_n}, 32'd1);
        check("R9 no pop reg", {31'd0, fifo_pop}, 32'd0);
        step();
        check_driven_high("R7");
        irdy_n = 1'b1;
        step();
        check_released("R7");
        check("R9 pop count reg", pop_count - p0, 32'd0);
        bus_idle();
    endtask

    task automatic t_ioread();
        addr_phase(BASE + 32'd11, IORD);
        check("R2 io claim", {31'd0, devsel_n}, 32'd0);
        frame_n = 1'b1; irdy_n = 1'b0;
        step();
        check("R3 io data", ad_out, bank_word(2));
        step();
        irdy_n = 1'b1;
        step();
        bus_idle();
    endtask

    task automatic t_no_claim(input string req, input logic [31:0] a, input logic [3:0] cmd);
        addr_phase(a, cmd);
        check({req, " no devsel_oe"}, {31'd0, devsel_oe}, 32'd0);
        frame_n = 1'b1; irdy_n = 1'b0;
        step();
        check_released(req);
        check({req, " levels"}, {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
        step();
        check_released(req);
        bus_idle();
    endtask

    task automatic t_waits();
        addr_phase(BASE + 32'd4, MEMRD);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R4 wait trdy/stop/devsel", {29'd0, trdy_n, stop_n, devsel_n}, 32'd6);
        end
        frame_n = 1'b1; irdy_n = 1'b0;
        step();
        check("R4 after waits", {30'd0, trdy_n, stop_n}, 32'd1);
        check("R4 data", ad_out, bank_word(1));
        step();
        check_driven_high("R4");
        irdy_n = 1'b1;
        step();
        bus_idle();
    endtask

    task automatic t_burst(input bit wait_first);
        addr_phase(BASE + 32'd24, MEMRD);
        if (wait_first) begin
            step();
            check("R4 wait not burst", {30'd0, stop_n, trdy_n}, 32'd3);
        end
        irdy_n = 1'b0;
        step();
        check("R6 trdy+stop", {30'd0, trdy_n, stop_n}, 32'd0);
        check("R6 data", ad_out, bank_word(6));
        step();
        check("R6 after xfer trdy", {30'd0, trdy_n, trdy_oe}, 32'd3);
        check("R6 stop/devsel held", {30'd0, stop_n, devsel_n}, 32'd0);
        step();
        check("R10 stop held", {30'd0, stop_n, trdy_n}, 32'd1);
        frame_n = 1'b1;
        step();
        check_driven_high("R6");
        irdy_n = 1'b1;
        step();
        check_released("R6");
        bus_idle();
    endtask

    task automatic t_hold();
        addr_phase(BASE + 32'd16, MEMRD);
        frame_n = 1'b1; irdy_n = 1'b0;
        step();
        check("R5 trdy", {31'd0, trdy_n}, 32'd0);
        irdy_n = 1'b1;
        step();
        check("R5 trdy held", {30'd0, trdy_n, devsel_n}, 32'd0);
        check("R5 data held", ad_out, bank_word(4));
        irdy_n = 1'b0;
        step();
        check_driven_high("R5");
        irdy_n = 1'b1;
        step();
        bus_idle();
    endtask

    task automatic t_fifo_pop();
        int p0 = pop_count;
        fifo_empty = 1'b0; fifo_data = 32'hF1F0_0001;
        addr_phase(BASE + 32'd12, MEMRD);
        frame_n = 1'b1; irdy_n = 1'b0;
        step();
        check("R9 fifo data", ad_out, 32'hF1F0_0001);
        check("R9 pop at xfer", {31'd0, fifo_pop}, 32'd1);
        step();
        check("R9 pop ends", {31'd0, fifo_pop}, 32'd0);
        irdy_n = 1'b1;
        step();
        check("R9 one pop", pop_count - p0, 32'd1);
        bus_idle();
    endtask

    task automatic t_fifo_empty();
        int p0 = pop_count;
        fifo_empty = 1'b1;
        addr_phase(BASE + 32'd12, MEMRD);
        irdy_n = 1'b0;
        step();
        check("R8 retry stop", {30'd0, stop_n, trdy_n}, 32'd1);
        check("R8 no pop", {31'd0, fifo_pop}, 32'd0);
        step();
        check("R10 retry held", {29'd0, stop_n, trdy_n, devsel_n}, 32'd2);
        frame_n = 1'b1;
        step();
        check_driven_high("R8");
        irdy_n = 1'b1;
        step();
        check_released("R8");
        check("R8 pop count", pop_count - p0, 32'd0);
        bus_idle();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) reg_bank[i*32 +: 32] = bank_word(i);
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        step();
        rst_n = 1'b1;
        bus_idle();
        t_single_reg();
        t_ioread();
        t_no_claim("R2 outside window", BASE + 32'd32, MEMRD);
        t_no_claim("R2 write command", BASE + 32'd8, 4'b0111);
        t_no_claim("R2 misaligned mem", BASE + 32'd9, MEMRD);
        t_waits();
        t_burst(1'b0);
        t_burst(1'b1);
        t_hold();
        t_fifo_pop();
        t_fifo_empty();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule